// File: doc/BRIEF.md
# Interrupt Level Encoder with Autovector Steering

This block sits between three peripheral interrupt sources and a processor whose package has only two interrupt priority inputs. It collects the three active-low device requests, synchronises them to the processor clock, picks the one with the highest priority and encodes that priority onto the two priority pins. The serial controller is assigned level 7, the multifunction peripheral level 5 and the parallel interface level 2.

When the processor runs an interrupt acknowledge cycle, the block recognises it from the function code and address strobe and reads the level being acknowledged from the low address bits. A level 7 or level 5 acknowledge is steered to that device's own acknowledge strobe, so that device can put its vector on the bus. A level 2 acknowledge instead asserts the valid-peripheral line, so the processor takes an autovector. The decode is combinational, so it follows the bus cycle with no added clock latency.

Top module: `intr_level_encoder`

## Requirements
- R1: While rst_ni is low, ipl_n_o is 2'b11. With as_ni high, every bit of iack_n_o and vpa_no is high.
- R2: An active (low) request on req_n_i[0] (serial, level 7) drives ipl_n_o to 2'b00.
- R3: An active request on req_n_i[1] (multifunction, level 5) is the highest active request. It drives ipl_n_o to 2'b01: bit 1, the combined IPL2/IPL0 pin, is low and bit 0, the IPL1 pin, is high.
- R4: An active request on req_n_i[2] (parallel, level 2) is the only active request. It drives ipl_n_o to 2'b10.
- R5: With no request active, ipl_n_o is 2'b11.
- R6: When several requests are active, the encoded level is that of the highest-level active request.
- R7: A change on req_n_i reaches ipl_n_o after exactly SYNC_STAGES rising clock edges (default 2), and not after fewer.
- R8: An acknowledge cycle is fc_i == 3'b111 with as_ni low. With addr_i == 3'd7 it drives iack_n_o[0] low and leaves all other strobes high.
- R9: An acknowledge cycle with addr_i == 3'd5 drives iack_n_o[1] low and leaves all other strobes high.
- R10: An acknowledge cycle with addr_i == 3'd2 drives vpa_no low and leaves every bit of iack_n_o high. iack_n_o[2] never goes low.
- R11: Outside an acknowledge cycle, or when addr_i holds any level other than 7, 5 or 2, all strobes stay high. At most one strobe is low at any time.
- R12: The acknowledge decode does not depend on the requests that are pending in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_n_i | input | 3 | Device requests, active low: [0] serial, [1] multifunction, [2] parallel |
| fc_i | input | 3 | Processor function code |
| as_ni | input | 1 | Address strobe, active low |
| addr_i | input | 3 | Address bits A3..A1, the level being acknowledged |
| ipl_n_o | output | 2 | Priority pins, active low: [1] combined IPL2/IPL0, [0] IPL1 |
| iack_n_o | output | 3 | Per-device acknowledge strobes, active low |
| vpa_no | output | 1 | Autovector request, active low |

## Verification
Two functions can act in the same cycle: an acknowledge cycle being decoded, and a request change travelling through the synchroniser to the priority pins. The bench provokes this by changing req_n_i at the same negative edge on which it presents an acknowledge cycle. It uses both directed cases and seeded random mixes. The strobes are judged one time unit later against a bench decode that ignores the requests. The pins are judged one edge later, where they must still hold the old level, and again after the second edge, where they must hold the new level.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int NUM_SRC = 3;
  typedef logic [2:0] lvl_t;
  // source index -> cpu level; index order has no priority meaning
  localparam lvl_t SRC_LVL [NUM_SRC] = '{3'd7, 3'd5, 3'd2};
  // sources that get an autovector instead of a strobe
  localparam logic [NUM_SRC-1:0] SRC_AUTO = 3'b100;
  localparam logic [2:0] FC_CPU_SPACE = 3'b111;

  // two-pin package: pin1 = IPL2/IPL0 tied, pin0 = IPL1
  function automatic logic [1:0] lvl_to_pins(lvl_t l);
    return {~l[2], ~l[1]};
  endfunction
endpackage

// File: rtl/intr_req_sync.sv
module intr_req_sync #(
  parameter int NUM_SRC     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_n_i,
  output logic [NUM_SRC-1:0] act_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [SYNC_STAGES-1:0] shreg;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) shreg <= '1;
      else if (SYNC_STAGES == 1) shreg <= req_n_i[s];
      else shreg <= {shreg[SYNC_STAGES-2:0], req_n_i[s]};
    end
    assign act_o[s] = ~shreg[SYNC_STAGES-1];
  end
endmodule

// File: rtl/intr_prio_enc.sv
module intr_prio_enc
  import intr_pkg::*;
(
  input  logic [NUM_SRC-1:0] act_i,
  output logic [1:0]         ipl_n_o
);
  lvl_t best;
  always_comb begin
    best = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (act_i[s] && SRC_LVL[s] > best) best = SRC_LVL[s];
  end
  assign ipl_n_o = lvl_to_pins(best);
endmodule

// File: rtl/intr_ack_decode.sv
module intr_ack_decode
  import intr_pkg::*;
(
  input  logic [2:0]         fc_i,
  input  logic               as_ni,
  input  logic [2:0]         addr_i,
  output logic [NUM_SRC-1:0] iack_n_o,
  output logic               vpa_no
);
  logic               ack_cyc;
  logic [NUM_SRC-1:0] hit;
  assign ack_cyc = !as_ni && (fc_i == FC_CPU_SPACE);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_hit
    assign hit[s] = ack_cyc && (addr_i == SRC_LVL[s]);
    if (SRC_AUTO[s]) begin : g_auto
      assign iack_n_o[s] = 1'b1;
    end else begin : g_strb
      assign iack_n_o[s] = ~hit[s];
    end
  end
  assign vpa_no = ~|(hit & SRC_AUTO);
endmodule

// File: rtl/intr_level_encoder.sv
module intr_level_encoder
  import intr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_n_i,
  input  logic [2:0]         fc_i,
  input  logic               as_ni,
  input  logic [2:0]         addr_i,
  output logic [1:0]         ipl_n_o,
  output logic [NUM_SRC-1:0] iack_n_o,
  output logic               vpa_no
);
  logic [NUM_SRC-1:0] act;

  intr_req_sync #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_n_i(req_n_i), .act_o(act)
  );

  intr_prio_enc u_enc (.act_i(act), .ipl_n_o(ipl_n_o));

  intr_ack_decode u_ack (
    .fc_i(fc_i), .as_ni(as_ni), .addr_i(addr_i),
    .iack_n_o(iack_n_o), .vpa_no(vpa_no)
  );
endmodule

// File: rtl/intr_level_encoder_chk.sv
module intr_level_encoder_chk
  import intr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] req_n_i,
  input logic [2:0]         fc_i,
  input logic               as_ni,
  input logic [2:0]         addr_i,
  input logic [1:0]         ipl_n_o,
  input logic [NUM_SRC-1:0] iack_n_o,
  input logic               vpa_no
);
  logic [3:0] lo7_cnt, idle_cnt;
  logic       ack;
  assign ack = !as_ni && fc_i == 3'b111;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo7_cnt  <= '0;
      idle_cnt <= '0;
    end else begin
      lo7_cnt  <= req_n_i[0]  ? 4'd0 : (lo7_cnt  == 4'hf ? lo7_cnt  : lo7_cnt  + 4'd1);
      idle_cnt <= !(&req_n_i) ? 4'd0 : (idle_cnt == 4'hf ? idle_cnt : idle_cnt + 4'd1);
    end
  end

  assert_lvl7_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(lo7_cnt) >= SYNC_STAGES) |-> (ipl_n_o == 2'b00));
  assert_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(idle_cnt) >= SYNC_STAGES) |-> (ipl_n_o == 2'b11));
  assert_iack7_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && addr_i == 3'd7) |-> (!iack_n_o[0] && vpa_no));
  assert_autovec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && addr_i == 3'd2) |-> (!vpa_no && &iack_n_o));
  assert_no_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack |-> (&iack_n_o && vpa_no));
  assert_one_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~{iack_n_o, vpa_no}) <= 1);
endmodule

bind intr_level_encoder intr_level_encoder_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_n_i(req_n_i), .fc_i(fc_i), .as_ni(as_ni),
  .addr_i(addr_i), .ipl_n_o(ipl_n_o), .iack_n_o(iack_n_o), .vpa_no(vpa_no)
);

// File: tb/sim_intr_level_encoder.sv
module sim_intr_level_encoder;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] req_n_i = 3'b111;
  logic [2:0] fc_i = 3'b000;
  logic       as_ni = 1'b1;
  logic [2:0] addr_i = 3'd0;
  logic [1:0] ipl_n_o;
  logic [2:0] iack_n_o;
  logic       vpa_no;

  int total = 0;
  int bad = 0;
  logic [2:0] prev_req = 3'b111;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  intr_level_encoder u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_n_i(req_n_i), .fc_i(fc_i), .as_ni(as_ni),
    .addr_i(addr_i), .ipl_n_o(ipl_n_o), .iack_n_o(iack_n_o), .vpa_no(vpa_no)
  );

  function automatic logic [1:0] exp_ipl(logic [2:0] rq);
    if (!rq[0]) return 2'b00;
    if (!rq[1]) return 2'b01;
    if (!rq[2]) return 2'b10;
    return 2'b11;
  endfunction

  // {vpa_no, iack_n_o[2:0]}
  function automatic logic [3:0] exp_strb(logic as_n, logic [2:0] fc, logic [2:0] a);
    if (as_n || fc != 3'b111) return 4'b1111;
    case (a)
      3'd7:    return 4'b1110;
      3'd5:    return 4'b1101;
      3'd2:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive at negedge; strobes checked at once, pins after 1 and 2 edges
  task automatic step(input logic [2:0] rq, input logic asn, input logic [2:0] fc,
                      input logic [2:0] a, input string tag);
    @(negedge clk_i);
    req_n_i = rq; as_ni = asn; fc_i = fc; addr_i = a;
    #1;
    chk({tag, " strobes R8 R9 R10 R11 R12"}, {vpa_no, iack_n_o}, exp_strb(asn, fc, a));
    @(negedge clk_i);
    if (exp_ipl(rq) != exp_ipl(prev_req))
      chk({tag, " early R7"}, {2'b00, ipl_n_o}, {2'b00, exp_ipl(prev_req)});
    @(negedge clk_i);
    chk({tag, " ipl R2 R3 R4 R5 R6 R7"}, {2'b00, ipl_n_o}, {2'b00, exp_ipl(rq)});
    prev_req = rq;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog R1 actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0de));
    #(CLK_PERIOD * 3);
    chk("reset ipl R1", {2'b00, ipl_n_o}, 4'b0011);
    chk("reset strobes R1", {vpa_no, iack_n_o}, 4'b1111);
    @(negedge clk_i);
    rst_ni = 1'b1;

    step(3'b111, 1'b1, 3'b000, 3'd0, "idle R5");
    step(3'b110, 1'b1, 3'b000, 3'd0, "serial R2");
    step(3'b101, 1'b1, 3'b000, 3'd0, "multi R3");
    step(3'b011, 1'b1, 3'b000, 3'd0, "parallel R4");
    step(3'b010, 1'b1, 3'b000, 3'd0, "prio 7over2 R6");
    step(3'b001, 1'b1, 3'b000, 3'd0, "prio 5over2 R6");
    step(3'b000, 1'b1, 3'b000, 3'd0, "prio all R6");
    step(3'b111, 1'b0, 3'b111, 3'd7, "ack7 R8");
    step(3'b011, 1'b0, 3'b111, 3'd5, "ack5 R9");
    step(3'b110, 1'b0, 3'b111, 3'd2, "ack2 R10");
    step(3'b101, 1'b0, 3'b111, 3'd4, "ack4 R11");
    step(3'b111, 1'b0, 3'b110, 3'd7, "fc110 R11");
    step(3'b000, 1'b1, 3'b111, 3'd5, "as high R11");
    step(3'b100, 1'b0, 3'b111, 3'd2, "concurrent R12");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom();
      step(r[2:0], r[3], (r[4] ? 3'b111 : r[7:5]), r[10:8], "random R6 R11 R12");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule